// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the arithmetic and logic unit of a small multi-cycle register CPU. It takes two 16-bit operands and a 4-bit operation code. It produces a 16-bit result and a write-back enable in the same cycle. Alongside them it holds a registered five-bit status word with overflow, carry, negative, zero and all-ones flags. The flags sit in the low bits of that word, so the sequencer can merge them into its status register without reshuffling.

A register-or-immediate select chooses the second operand. In immediate mode, only the low four bits of the second operand port are used, and they are zero-extended. This lets the same opcodes serve register and immediate forms. A compare subtracts and updates every flag but withholds write-back, so a register test is an immediate compare against zero.

The datapath is purely combinational. Operands are sampled whenever the sequencer chooses, so there is no valid/ready pairing and no back-pressure. The only state is the flag register. It loads on a clock edge when the flag enable is high and the opcode is defined.

Top module: `falu_top`

## Requirements
- R1: Opcode 0000 gives the bitwise inverse of A, 0001 gives AND, 0010 gives OR, 0011 gives XOR, and 0110 passes the second operand. Every defined opcode except 0111 drives `wr_en` high.
- R2: Opcode 0100 adds and 0101 subtracts (A minus B), both modulo 2^16. C is the carry out for the add and the borrow (A < B unsigned) for the subtract. V is set on signed two's-complement overflow.
- R3: Opcode 0111 computes A minus B and sets all flags exactly as 0101 would. `result` carries the difference, but `wr_en` is low.
- R4: When `use_imm` is high, the second operand is `op_b[3:0]` zero-extended to 16 bits, and the upper bits of `op_b` have no effect.
- R5: Opcode 1000 is a logical right shift, 1001 an arithmetic right shift and 1010 a left shift. Each shifts by the low four bits of the second operand. C is the last bit shifted out. A shift by zero returns A unchanged, with C cleared.
- R6: The flag word layout is bit4 V, bit3 C, bit2 N (result bit 15), bit1 Z (result is 0x0000) and bit0 X (result is 0xFFFF).
- R7: For the logic ops and the move, C and V are cleared. For the shifts, V is cleared.
- R8: Opcodes 1011 to 1111 give a zero result with `wr_en` low, and the flags keep their value even with `flag_en` high.
- R9: `flags_q` changes only at a rising clock edge when `flag_en` is high. It then takes the flags of the operation presented in that cycle.
- R10: An active-low `rst_n` clears all five flags.
- R11: For opcode 0000, the second operand is treated as zero, so `op_b` and `use_imm` do not change the result or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand, or immediate in its low 4 bits |
| use_imm | input | 1 | Selects the zero-extended immediate as the second operand |
| op_code | input | 4 | Operation code |
| flag_en | input | 1 | Allows the flag register to load at the next edge |
| result | output | 16 | Combinational result |
| wr_en | output | 1 | Result should be written back |
| flags_q | output | 5 | Registered status flags {V,C,N,Z,X} |

## Verification
The bench builds the block with its default 16-bit data width and 4-bit immediate. This puts the sign-bit overflow boundaries (0x7FFF+1, 0x8000−1), the all-ones result and the full 0 to 15 shift range within reach of directed vectors. A behavioural integer model predicts the result, the write enable and the flag word on every cycle. Random operands, opcodes (including the undefined ones), immediate selects and flag enables then cover the mixes the directed cases miss.

// File: rtl/falu_pkg.sv
package falu_pkg;

  typedef enum logic [3:0] {
    OP_NOT  = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_MOV  = 4'd6,
    OP_CMP  = 4'd7,
    OP_SHR  = 4'd8,
    OP_SSHR = 4'd9,
    OP_SHL  = 4'd10
  } falu_op_e;

  localparam int FLAG_W = 5;
  localparam int FL_V = 4;
  localparam int FL_C = 3;
  localparam int FL_N = 2;
  localparam int FL_Z = 1;
  localparam int FL_X = 0;

  // packed order matches the status-word bit positions (v is bit 4)
  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
    logic x;
  } falu_flags_t;

  typedef enum logic [1:0] {
    SH_RIGHT_LOG = 2'd0,
    SH_RIGHT_ARI = 2'd1,
    SH_LEFT      = 2'd2
  } falu_shmode_e;

  function automatic logic op_defined(input logic [3:0] op);
    return op <= OP_SHL;
  endfunction

endpackage

// File: rtl/falu_operand_sel.sv
module falu_operand_sel
  import falu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 4
) (
  input  logic [DATA_W-1:0] b_in,
  input  logic              use_imm,
  input  logic [3:0]        op,
  output logic [DATA_W-1:0] b_eff
);
  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    if (op == OP_NOT) begin
      b_eff = '0;                              // R11: operand unused
    end else if (use_imm) begin
      b_eff = {{PAD_W{1'b0}}, b_in[IMM_W-1:0]}; // R4: zero extension
    end else begin
      b_eff = b_in;
    end
  end
endmodule

// File: rtl/falu_shifter.sv
module falu_shifter
  import falu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   amt,
  input  falu_shmode_e      mode,
  output logic [DATA_W-1:0] y,
  output logic              carry
);
  // one guard bit beyond the word catches the last bit shifted out
  localparam int W1 = DATA_W + 1;

  logic [SH_W:0][W1-1:0] rchain;
  logic [SH_W:0][W1-1:0] lchain;
  logic                  fill;

  assign fill      = (mode == SH_RIGHT_ARI) ? a[DATA_W-1] : 1'b0;
  assign rchain[0] = {a, 1'b0};
  assign lchain[0] = {1'b0, a};

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign rchain[s+1] = amt[s] ? {{STEP{fill}}, rchain[s][W1-1:STEP]} : rchain[s];
    assign lchain[s+1] = amt[s] ? {lchain[s][W1-1-STEP:0], {STEP{1'b0}}} : lchain[s];
  end

  always_comb begin
    if (mode == SH_LEFT) begin
      y     = lchain[SH_W][DATA_W-1:0];
      carry = lchain[SH_W][DATA_W];
    end else begin
      y     = rchain[SH_W][W1-1:1];
      carry = rchain[SH_W][0];
    end
  end
endmodule

// File: rtl/falu_compute.sv
module falu_compute
  import falu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        op,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output falu_flags_t       flags,
  output logic              flags_ok
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int MSB  = DATA_W - 1;

  logic [DATA_W:0]   sum_w;
  logic [DATA_W:0]   dif_w;
  logic [DATA_W-1:0] sh_y;
  logic              sh_c;
  falu_shmode_e      sh_mode;
  logic              c_bit;
  logic              v_bit;

  assign sum_w = {1'b0, a} + {1'b0, b};
  assign dif_w = {1'b0, a} - {1'b0, b};

  always_comb begin
    case (op)
      OP_SHL:  sh_mode = SH_LEFT;
      OP_SSHR: sh_mode = SH_RIGHT_ARI;
      default: sh_mode = SH_RIGHT_LOG;
    endcase
  end

  falu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .a    (a),
    .amt  (b[SH_W-1:0]),
    .mode (sh_mode),
    .y    (sh_y),
    .carry(sh_c)
  );

  always_comb begin
    result   = '0;
    c_bit    = 1'b0;
    v_bit    = 1'b0;
    wr_en    = 1'b1;
    flags_ok = 1'b1;
    case (op)
      OP_NOT: result = ~a;
      OP_AND: result = a & b;
      OP_OR:  result = a | b;
      OP_XOR: result = a ^ b;
      OP_MOV: result = b;
      OP_ADD: begin
        result = sum_w[DATA_W-1:0];
        c_bit  = sum_w[DATA_W];
        v_bit  = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
      end
      OP_SUB, OP_CMP: begin
        result = dif_w[DATA_W-1:0];
        c_bit  = dif_w[DATA_W];
        v_bit  = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
        wr_en  = (op != OP_CMP);
      end
      OP_SHR, OP_SSHR, OP_SHL: begin
        result = sh_y;
        c_bit  = sh_c;
      end
      default: begin
        wr_en    = 1'b0;
        flags_ok = 1'b0;
      end
    endcase
  end

  assign flags.v = v_bit;
  assign flags.c = c_bit;
  assign flags.n = result[MSB];
  assign flags.z = (result == '0);
  assign flags.x = (result == '1);
endmodule

// File: rtl/falu_flag_reg.sv
module falu_flag_reg
  import falu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  falu_flags_t d,
  output falu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

  // R9: without a load the register keeps its value
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/falu_top.sv
module falu_top
  import falu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              use_imm,
  input  logic [3:0]        op_code,
  input  logic              flag_en,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [FLAG_W-1:0] flags_q
);
  logic [DATA_W-1:0] b_eff;
  falu_flags_t       flags_d;
  falu_flags_t       flags_r;
  logic              flags_ok;

  falu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .b_in   (op_b),
    .use_imm(use_imm),
    .op     (op_code),
    .b_eff  (b_eff)
  );

  falu_compute #(.DATA_W(DATA_W)) u_core (
    .a       (op_a),
    .b       (b_eff),
    .op      (op_code),
    .result  (result),
    .wr_en   (wr_en),
    .flags   (flags_d),
    .flags_ok(flags_ok)
  );

  falu_flag_reg u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .load (flag_en && flags_ok),
    .d    (flags_d),
    .q    (flags_r)
  );

  assign flags_q = flags_r;

  assert_cmp_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CMP) |-> !wr_en);

  assert_undef_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_defined(op_code) |-> (!wr_en && result == '0));

  assert_undef_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_defined(op_code) |=> $stable(flags_q));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_defined(op_code)) |=> (flags_q[FL_Z] == ($past(result) == '0)));

  assert_zx_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_q[FL_Z] && flags_q[FL_X]));

  assert_logic_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && (op_code <= OP_XOR || op_code == OP_MOV)) |=> (!flags_q[FL_C] && !flags_q[FL_V]));

  assert_shift_no_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op_code >= OP_SHR && op_code <= OP_SHL) |=> !flags_q[FL_V]);
endmodule

// File: tb/falu_top_tb_top.sv
`timescale 1ns/1ps
module falu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        use_imm = 1'b0;
  logic [3:0]  op_code = '0;
  logic        flag_en = 1'b0;
  logic [15:0] result;
  logic        wr_en;
  logic [4:0]  flags_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] exp_flags = '0;

  always #2.5 clk = ~clk;

  falu_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .use_imm(use_imm),
    .op_code(op_code), .flag_en(flag_en), .result(result), .wr_en(wr_en),
    .flags_q(flags_q)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int sval(input logic [15:0] v);
    return v[15] ? int'(v) - 65536 : int'(v);
  endfunction

  // behavioural model from the requirements
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic imm,
                       input logic [3:0] op, output logic [15:0] r, output logic w,
                       output logic [4:0] f, output logic upd);
    logic [15:0] bb;
    logic c, v;
    int n, t;
    bb = imm ? {12'd0, b[3:0]} : b;
    if (op == 4'd0) bb = '0;
    c = 0; v = 0; w = 1; upd = 1; r = '0;
    n = int'(bb[3:0]);
    case (op)
      4'd0: r = ~a;
      4'd1: r = a & bb;
      4'd2: r = a | bb;
      4'd3: r = a ^ bb;
      4'd6: r = bb;
      4'd4: begin
        t = int'(a) + int'(bb); r = t[15:0]; c = t > 65535;
        t = sval(a) + sval(bb); v = (t > 32767) || (t < -32768);
      end
      4'd5, 4'd7: begin
        r = a - bb; c = a < bb;
        t = sval(a) - sval(bb); v = (t > 32767) || (t < -32768);
        w = (op == 4'd5);
      end
      4'd8: begin r = a >> n; c = (n != 0) ? a[n-1] : 1'b0; end
      4'd9: begin r = 16'($signed(a) >>> n); c = (n != 0) ? a[n-1] : 1'b0; end
      4'd10: begin r = a << n; c = (n != 0) ? a[16-n] : 1'b0; end
      default: begin w = 0; upd = 0; end
    endcase
    f = {v, c, r[15], r == 16'h0000, r == 16'hFFFF};
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic imm);
    if (imm && op != 4'd0) return "R4";
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd6: return "R1";
      4'd4, 4'd5: return "R2";
      4'd7: return "R3";
      4'd8, 4'd9, 4'd10: return "R5";
      default: return "R8";
    endcase
  endfunction

  // called at a falling edge; leaves at the next falling edge
  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic imm,
                      input logic [3:0] op, input logic en, input string tag);
    logic [15:0] r; logic w, upd; logic [4:0] f;
    string t, tf;
    op_a = a; op_b = b; use_imm = imm; op_code = op; flag_en = en;
    model(a, b, imm, op, r, w, f, upd);
    t  = (tag != "") ? tag : tag_of(op, imm);
    tf = (tag != "") ? tag : (en ? "R6" : "R9");
    #1;
    check(t, "result", result, r);
    check(t, "wr_en", {15'd0, wr_en}, {15'd0, w});
    @(posedge clk);
    if (en && upd) exp_flags = f;
    @(negedge clk);
    check(tf, "flags", {11'd0, flags_q}, {11'd0, exp_flags});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "flags in reset", {11'd0, flags_q}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "flags after reset", {11'd0, flags_q}, 16'd0);

    step(16'h7FFF, 16'h0001, 0, 4'd4, 1, "R2");   // signed overflow, N
    step(16'hFFFF, 16'h0001, 0, 4'd4, 1, "R2");   // carry, Z
    step(16'h0000, 16'h0001, 0, 4'd5, 1, "R2");   // borrow, N, X
    step(16'h8000, 16'h0001, 0, 4'd5, 1, "R2");   // negative overflow
    step(16'h1234, 16'h1234, 0, 4'd7, 1, "R3");   // compare equal
    step(16'h0000, 16'h0000, 1, 4'd7, 1, "R3");   // test register via immediate
    step(16'h0010, 16'hFFF5, 1, 4'd4, 1, "R4");   // immediate zero-extended 5
    step(16'h00FF, 16'hABC0, 1, 4'd6, 1, "R4");   // immediate move of 0
    step(16'h0F0F, 16'h1234, 0, 4'd0, 1, "R11");
    step(16'h0F0F, 16'hFFFF, 1, 4'd0, 1, "R11");
    step(16'h8000, 16'h0001, 0, 4'd10, 1, "R5");  // C out, Z
    step(16'h8000, 16'h000F, 0, 4'd9, 1, "R5");   // arithmetic fill to all ones
    step(16'h8001, 16'h0000, 0, 4'd8, 1, "R5");   // shift by zero
    step(16'hF00F, 16'h0004, 0, 4'd8, 1, "R5");
    step(16'hFFFF, 16'h0001, 0, 4'd4, 1, "R2");   // set C
    step(16'hF0F0, 16'h0FFF, 0, 4'd1, 1, "R7");   // logic clears C and V
    step(16'h7FFF, 16'h0001, 0, 4'd4, 1, "R2");   // set V
    step(16'h4000, 16'h0001, 0, 4'd10, 1, "R7");  // shift clears V
    step(16'h0000, 16'h0000, 0, 4'd11, 1, "R8");
    step(16'hFFFF, 16'hFFFF, 0, 4'd15, 1, "R8");
    step(16'h0000, 16'h0000, 0, 4'd5, 0, "R9");   // disabled load keeps flags

    for (int i = 0; i < 400; i++) begin
      step(16'($urandom), 16'($urandom), 1'($urandom), 4'($urandom), ($urandom % 4) != 0, "");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule